// File: doc/BRIEF.md
# Fetch Redirect Controller with Registered Exceptions

This controller sits between the execute side of a small two-stage in-order core and its instruction fetch unit. Each cycle it decides whether fetch keeps streaming sequential addresses or jumps to a new address. A jump is triggered by a taken branch, a jump, an exception or the end of reset. When it jumps, it raises a redirect strobe and a pipeline flush for exactly one cycle. It also presents the new fetch address and a code naming the reason for the jump.

Every exception input is caught in a flip-flop before it can affect anything visible at the outputs. The exception sources are a load/store fault, a decoder illegal instruction, a CSR illegal access, and an environment call or breakpoint. A dedicated flush state spends the cycle after detection driving the redirect, so exception handling keeps its two-cycle cost. The redirect strobe, the cause code and the fetch-address select all come from registered state.

A taken branch follows the same timing. Its decision and target are registered, and the target is applied in the next cycle. Exceptions go to a fixed vector: a base address plus four times the cause code.

Top module: `fr_redirect_ctrl`

## Requirements
- R1: While reset is held, and in the first cycle after it is released, `redirect_o` and `flush_o` are 1, `fetch_addr_o` equals `BOOT_ADDR` and `cause_o` is 5. The cycle after that is a normal run cycle.
- R2: In any cycle without a redirect, `redirect_o` and `flush_o` are 0, `cause_o` is 0 and `fetch_addr_o` equals `seq_addr_i`.
- R3: Suppose an exception input is high in a cycle that is not itself a redirect cycle. Then `redirect_o` and `flush_o` do not react in that cycle. They rise in the following cycle, even if the input was high for only one cycle.
- R4: A decoder illegal instruction and a CSR illegal access both produce cause code 2 by the same registered route.
- R5: When exception inputs are high together, the cause is chosen by fixed priority. A load/store fault (code 1) beats an illegal instruction (code 2), which beats an environment call or breakpoint (code 3).
- R6: During an exception redirect, `fetch_addr_o` equals `VEC_BASE + 4 * cause_o`.
- R7: Suppose `branch_taken_i` is high, with no exception, in a cycle that is not a redirect cycle. Then the next cycle redirects to the `branch_target_i` value sampled in that cycle, with cause code 4.
- R8: When an exception and a taken branch arrive in the same cycle, the exception redirect is taken and the branch is dropped: no branch redirect follows.
- R9: Exception and branch inputs that are high during a redirect cycle are ignored. The next cycle is a plain run cycle.
- R10: A redirect lasts exactly one cycle, with `flush_o` equal to `redirect_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| lsu_fault_i | input | 1 | Load/store fault pulse |
| dec_illegal_i | input | 1 | Decoder illegal-instruction flag |
| csr_illegal_i | input | 1 | Illegal CSR access flag |
| env_trap_i | input | 1 | Environment call or breakpoint |
| branch_taken_i | input | 1 | Branch/jump decision is taken |
| branch_target_i | input | ADDR_W | Computed branch or jump target |
| seq_addr_i | input | ADDR_W | Next sequential prefetch address |
| redirect_o | output | 1 | Fetch redirect strobe |
| flush_o | output | 1 | Pipeline flush |
| fetch_addr_o | output | ADDR_W | Selected fetch address |
| cause_o | output | 3 | Redirect cause (0 none, 1 lsu, 2 illegal, 3 env, 4 branch, 5 boot) |

## Verification
The hardest situations to reach are inputs that land on a redirect cycle. One case is a branch or exception arriving during the flush cycle. Another is an exception arriving during a branch redirect or during the boot cycle. These are reachable only one cycle after a specific earlier event. Directed sequences hold the inputs high across two consecutive cycles, so the second cycle falls on the redirect. A long random phase with dense exception and branch traffic then produces these overlaps repeatedly. A behavioural model in the bench is compared on every cycle.

// File: rtl/fr_pkg.sv
package fr_pkg;

    localparam int CAUSE_W = 3;

    typedef enum logic [CAUSE_W-1:0] {
        CAUSE_NONE    = 3'd0,
        CAUSE_LSU     = 3'd1,
        CAUSE_ILLEGAL = 3'd2,
        CAUSE_ENV     = 3'd3,
        CAUSE_BRANCH  = 3'd4,
        CAUSE_BOOT    = 3'd5
    } cause_e;

    typedef enum logic [1:0] {
        ST_RUN   = 2'd0,
        ST_FLUSH = 2'd1,
        ST_JUMP  = 2'd2
    } state_e;

    typedef struct packed {
        logic lsu;
        logic illegal;
        logic env;
    } exc_flags_t;

    function automatic cause_e pick_cause(input exc_flags_t f);
        if (f.lsu)          return CAUSE_LSU;
        else if (f.illegal) return CAUSE_ILLEGAL;
        else if (f.env)     return CAUSE_ENV;
        else                return CAUSE_NONE;
    endfunction

    function automatic logic any_exc(input exc_flags_t f);
        return f.lsu | f.illegal | f.env;
    endfunction

endpackage

// File: rtl/fr_exc_capture.sv
module fr_exc_capture
    import fr_pkg::*;
(
    input  logic       clk_i,
    input  logic       rst_i,
    input  logic       accept_i,
    input  logic       lsu_fault_i,
    input  logic       dec_illegal_i,
    input  logic       csr_illegal_i,
    input  logic       env_trap_i,
    output logic       raw_any_o,
    output exc_flags_t flags_q_o
);

    exc_flags_t raw;

    always_comb begin
        raw.lsu     = lsu_fault_i;
        raw.illegal = dec_illegal_i | csr_illegal_i;
        raw.env     = env_trap_i;
        raw_any_o   = accept_i & any_exc(raw);
    end

    // Sources are only sampled in accepting cycles; held through FLUSH.
    always_ff @(posedge clk_i) begin
        if (rst_i)         flags_q_o <= '0;
        else if (accept_i) flags_q_o <= raw;
    end

endmodule

// File: rtl/fr_fsm.sv
module fr_fsm
    import fr_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              exc_hit_i,
    input  logic              branch_taken_i,
    input  logic [ADDR_W-1:0] branch_target_i,
    output state_e            state_o,
    output logic              boot_o,
    output logic              accept_o,
    output logic [ADDR_W-1:0] br_tgt_q_o
);

    state_e state_q;
    logic   boot_q;

    assign accept_o = (state_q == ST_RUN) && !boot_q;
    assign state_o  = state_q;
    assign boot_o   = boot_q;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            state_q    <= ST_RUN;
            boot_q     <= 1'b1;
            br_tgt_q_o <= '0;
        end else begin
            boot_q <= 1'b0;
            if (accept_o) begin
                if (exc_hit_i) begin
                    state_q <= ST_FLUSH;
                end else if (branch_taken_i) begin
                    state_q    <= ST_JUMP;
                    br_tgt_q_o <= branch_target_i;
                end else begin
                    state_q <= ST_RUN;
                end
            end else begin
                state_q <= ST_RUN;
            end
        end
    end

endmodule

// File: rtl/fr_addr_sel.sv
module fr_addr_sel
    import fr_pkg::*;
#(
    parameter int              ADDR_W    = 32,
    parameter logic [ADDR_W-1:0] BOOT_ADDR = '0,
    parameter logic [ADDR_W-1:0] VEC_BASE  = '0
) (
    input  state_e            state_i,
    input  logic              boot_i,
    input  exc_flags_t        flags_i,
    input  logic [ADDR_W-1:0] br_tgt_i,
    input  logic [ADDR_W-1:0] seq_addr_i,
    input  logic              redirect_i,
    output cause_e            cause_o,
    output logic [ADDR_W-1:0] fetch_addr_o
);

    logic [ADDR_W-1:0] target;

    always_comb begin
        cause_o = CAUSE_NONE;
        target  = br_tgt_i;
        if (boot_i) begin
            cause_o = CAUSE_BOOT;
            target  = BOOT_ADDR;
        end else if (state_i == ST_FLUSH) begin
            cause_o = pick_cause(flags_i);
            target  = VEC_BASE + (ADDR_W'(cause_o) << 2);
        end else if (state_i == ST_JUMP) begin
            cause_o = CAUSE_BRANCH;
        end
        fetch_addr_o = redirect_i ? target : seq_addr_i;
    end

endmodule

// File: rtl/fr_redirect_ctrl.sv
module fr_redirect_ctrl
    import fr_pkg::*;
#(
    parameter int              ADDR_W    = 32,
    parameter logic [ADDR_W-1:0] BOOT_ADDR = 32'h0000_0080,
    parameter logic [ADDR_W-1:0] VEC_BASE  = 32'h0000_0100
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              lsu_fault_i,
    input  logic              dec_illegal_i,
    input  logic              csr_illegal_i,
    input  logic              env_trap_i,
    input  logic              branch_taken_i,
    input  logic [ADDR_W-1:0] branch_target_i,
    input  logic [ADDR_W-1:0] seq_addr_i,
    output logic              redirect_o,
    output logic              flush_o,
    output logic [ADDR_W-1:0] fetch_addr_o,
    output logic [CAUSE_W-1:0] cause_o
);

    state_e            state;
    logic              boot;
    logic              accept;
    logic              exc_hit;
    exc_flags_t        flags_q;
    logic [ADDR_W-1:0] br_tgt_q;
    cause_e            cause;

    fr_exc_capture u_cap (
        .clk_i         (clk_i),
        .rst_i         (rst_i),
        .accept_i      (accept),
        .lsu_fault_i   (lsu_fault_i),
        .dec_illegal_i (dec_illegal_i),
        .csr_illegal_i (csr_illegal_i),
        .env_trap_i    (env_trap_i),
        .raw_any_o     (exc_hit),
        .flags_q_o     (flags_q)
    );

    fr_fsm #(.ADDR_W(ADDR_W)) u_fsm (
        .clk_i           (clk_i),
        .rst_i           (rst_i),
        .exc_hit_i       (exc_hit),
        .branch_taken_i  (branch_taken_i),
        .branch_target_i (branch_target_i),
        .state_o         (state),
        .boot_o          (boot),
        .accept_o        (accept),
        .br_tgt_q_o      (br_tgt_q)
    );

    // Redirect is a pure function of registered state.
    assign redirect_o = !accept;
    assign flush_o    = redirect_o;

    fr_addr_sel #(
        .ADDR_W    (ADDR_W),
        .BOOT_ADDR (BOOT_ADDR),
        .VEC_BASE  (VEC_BASE)
    ) u_sel (
        .state_i      (state),
        .boot_i       (boot),
        .flags_i      (flags_q),
        .br_tgt_i     (br_tgt_q),
        .seq_addr_i   (seq_addr_i),
        .redirect_i   (redirect_o),
        .cause_o      (cause),
        .fetch_addr_o (fetch_addr_o)
    );

    assign cause_o = cause;

endmodule

// File: rtl/fr_redirect_chk.sv
module fr_redirect_chk #(
    parameter int              ADDR_W   = 32,
    parameter logic [ADDR_W-1:0] VEC_BASE = '0
) (
    input logic              clk_i,
    input logic              rst_i,
    input logic              lsu_fault_i,
    input logic              dec_illegal_i,
    input logic              csr_illegal_i,
    input logic              env_trap_i,
    input logic              branch_taken_i,
    input logic [ADDR_W-1:0] branch_target_i,
    input logic [ADDR_W-1:0] seq_addr_i,
    input logic              redirect_o,
    input logic              flush_o,
    input logic [ADDR_W-1:0] fetch_addr_o,
    input logic [2:0]        cause_o
);

    logic any_exc;
    assign any_exc = lsu_fault_i | dec_illegal_i | csr_illegal_i | env_trap_i;

    p_seq_r2: assert property (@(posedge clk_i) disable iff (rst_i)
        !redirect_o |-> (fetch_addr_o == seq_addr_i) && (cause_o == 3'd0) && !flush_o);

    p_exc_next_r3: assert property (@(posedge clk_i) disable iff (rst_i)
        (!redirect_o && any_exc) |=> redirect_o && flush_o && (cause_o >= 3'd1) && (cause_o <= 3'd3));

    p_lsu_first_r5: assert property (@(posedge clk_i) disable iff (rst_i)
        (!redirect_o && lsu_fault_i) |=> (cause_o == 3'd1));

    p_vector_r6: assert property (@(posedge clk_i) disable iff (rst_i)
        (redirect_o && (cause_o >= 3'd1) && (cause_o <= 3'd3))
            |-> (fetch_addr_o == VEC_BASE + (ADDR_W'(cause_o) << 2)));

    p_branch_r7: assert property (@(posedge clk_i) disable iff (rst_i)
        (!redirect_o && branch_taken_i && !any_exc)
            |=> redirect_o && (cause_o == 3'd4) && (fetch_addr_o == $past(branch_target_i)));

    p_one_cycle_r10: assert property (@(posedge clk_i) disable iff (rst_i)
        redirect_o |=> !redirect_o);

endmodule

bind fr_redirect_ctrl fr_redirect_chk #(.ADDR_W(ADDR_W), .VEC_BASE(VEC_BASE)) u_chk (.*);

// File: tb/fr_redirect_ctrl_tb.sv
module fr_redirect_ctrl_tb;

    localparam int CLK_PERIOD = 10;
    localparam logic [31:0] BOOT = 32'h0000_0080;
    localparam logic [31:0] VBASE = 32'h0000_0100;

    logic        clk = 1'b0;
    logic        rst_i;
    logic        lsu, dec, csr, env, br;
    logic [31:0] tgt, seq;
    logic        redirect_o, flush_o;
    logic [31:0] fetch_addr_o;
    logic [2:0]  cause_o;

    int errors = 0;
    int checks = 0;

    // reference model state
    int          m_state = 0;   // 0 run, 1 exception flush, 2 branch
    bit          m_boot  = 1'b1;
    int          m_cause = 0;
    logic [31:0] m_tgt   = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    fr_redirect_ctrl u_dut (
        .clk_i(clk), .rst_i(rst_i),
        .lsu_fault_i(lsu), .dec_illegal_i(dec), .csr_illegal_i(csr), .env_trap_i(env),
        .branch_taken_i(br), .branch_target_i(tgt), .seq_addr_i(seq),
        .redirect_o(redirect_o), .flush_o(flush_o),
        .fetch_addr_o(fetch_addr_o), .cause_o(cause_o)
    );

    task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic model_update();
        if (rst_i) begin
            m_boot = 1; m_state = 0; m_cause = 0;
        end else if (m_boot || m_state != 0) begin
            m_boot = 0; m_state = 0;
        end else if (lsu || dec || csr || env) begin
            m_state = 1;
            m_cause = lsu ? 1 : ((dec || csr) ? 2 : 3);
        end else if (br) begin
            m_state = 2; m_tgt = tgt;
        end
    endtask

    task automatic compare(input string tag);
        bit          er;
        int          ec;
        logic [31:0] ea;
        er = m_boot || (m_state != 0);
        if (m_boot)            begin ec = 5; ea = BOOT; end
        else if (m_state == 1) begin ec = m_cause; ea = VBASE + 32'(m_cause * 4); end
        else if (m_state == 2) begin ec = 4; ea = m_tgt; end
        else                   begin ec = 0; ea = seq; end
        chk(tag, "redirect", {31'b0, redirect_o}, {31'b0, er});
        chk(tag, "flush",    {31'b0, flush_o},    {31'b0, er});
        chk(tag, "cause",    {29'b0, cause_o},    32'(ec));
        chk(tag, "addr",     fetch_addr_o,        ea);
    endtask

    task automatic step(input string tag, input bit r, input bit l, input bit d, input bit c,
                        input bit e, input bit b, input logic [31:0] t);
        rst_i = r; lsu = l; dec = d; csr = c; env = e; br = b; tgt = t;
        seq = seq + 32'd4;
        @(posedge clk);
        model_update();
        #1;
        compare(tag);
    endtask

    task automatic idle(input string tag);
        step(tag, 0, 0, 0, 0, 0, 0, 32'h0);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
    end

    initial begin
        rst_i = 1; lsu = 0; dec = 0; csr = 0; env = 0; br = 0; tgt = '0; seq = 32'h1000;
        // R1 reset and boot redirect
        step("R1", 1, 0, 0, 0, 0, 0, 0);
        step("R1", 1, 0, 0, 0, 0, 0, 0);
        // R9 inputs during boot redirect ignored
        step("R9", 0, 1, 0, 0, 0, 1, 32'h2222_0000);
        idle("R2");
        idle("R2");
        // R3 single-cycle lsu pulse
        step("R3", 0, 1, 0, 0, 0, 0, 0);
        idle("R6");
        idle("R2");
        // R4 decoder and CSR illegal
        step("R4", 0, 0, 1, 0, 0, 0, 0);
        idle("R4");
        step("R4", 0, 0, 0, 1, 0, 0, 0);
        idle("R4");
        // R6 env trap vector
        step("R6", 0, 0, 0, 0, 1, 0, 0);
        idle("R6");
        // R5 priorities
        step("R5", 0, 1, 1, 1, 1, 0, 0);
        idle("R5");
        step("R5", 0, 0, 1, 0, 1, 0, 0);
        idle("R5");
        // R7 branch
        step("R7", 0, 0, 0, 0, 0, 1, 32'h0000_4A40);
        idle("R7");
        idle("R10");
        // R8 exception and branch together
        step("R8", 0, 0, 0, 0, 1, 1, 32'h0000_5000);
        idle("R8");
        idle("R8");
        // R9 branch and exception during flush cycle
        step("R9", 0, 0, 1, 0, 0, 0, 0);
        step("R9", 0, 1, 0, 0, 0, 1, 32'h0000_6000);
        idle("R9");
        // R9 exception during branch redirect cycle
        step("R9", 0, 0, 0, 0, 0, 1, 32'h0000_7000);
        step("R9", 0, 1, 1, 1, 1, 0, 0);
        idle("R9");
        // R10 back-to-back held exception gives alternating redirects
        step("R10", 0, 1, 0, 0, 0, 0, 0);
        step("R10", 0, 1, 0, 0, 0, 0, 0);
        step("R10", 0, 1, 0, 0, 0, 0, 0);
        idle("R10");
        // random traffic, mixed R5 R7 R8 R9
        for (int i = 0; i < 600; i++) begin
            step("R5_R7_R8_R9_mix", ($urandom % 97) == 0,
                 ($urandom % 6) == 0, ($urandom % 6) == 0, ($urandom % 7) == 0,
                 ($urandom % 6) == 0, ($urandom % 3) == 0, $urandom & 32'hFFFF_FFFC);
        end
        // reset again mid-run R1
        step("R1", 1, 0, 0, 0, 0, 1, 32'h0000_8000);
        idle("R1");
        idle("R2");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule